// File: doc/BRIEF.md
# Serial ADC Result Output Stage

This block carries finished converter results out to a DSP over a serial link clocked by an externally supplied bit clock. Each channel collects its successive-approximation result bits in an input shift register while a conversion runs. A convert command copies that register into a parallel holding latch, so the next conversion can start filling the input register at once. A separate load strobe moves the held word into an output shift register and raises a frame-sync pulse. The word then leaves one bit per bit-clock rising edge, most significant bit first.

Each channel has a serial tag input that feeds the low end of its output register. Tying one device's serial output to the tag input of the next device forms a daisy chain. After its own data word, the downstream device then emits the upstream device's word. One sync output is shared by all channels. Everything is clocked on the rising edge of the bit clock, and the reset is synchronous and active high.

Top module: `sadc_serial_out`

## Requirements
- R1: While reset is high at a rising edge, all registers clear: afterwards sync is 0, every serial output is 0, and loading without any convert sends an all-zero word.
- R2: On each edge where a channel's bit-valid input is 1, that channel's input register shifts left and takes the bit input at its least significant end. The first bit supplied becomes the MSB after W valid bits. Bits offered while bit-valid is 0 are ignored.
- R3: On an edge where convert is 1, the holding latch of every channel takes its input register. Without convert the latch keeps its value, so later input bits do not change what a load sends.
- R4: On an edge where load is 1, each output register takes its holding latch. From that edge the serial output shows the latch MSB.
- R5: sync is 1 for exactly the one bit-clock cycle after an edge where load was sampled high, and 0 in every other cycle.
- R6: On every edge where load is 0, the output register shifts one place toward the MSB. The serial output therefore presents the held word MSB first, one bit per edge, for W cycles.
- R7: The tag bit sampled at each edge enters the output register LSB. A tag bit sampled at edge e appears on the serial output after edge e+W-1, so the tag stream follows the local data with no gap.
- R8: When convert and load are both 1 on the same edge, the output register takes the latch value from before that edge, and the latch takes the new input register value.
- R9: Channels are independent. Each has its own bit inputs, tag input and serial output, and all channels share convert, load and sync.
- R10: With device A's serial outputs wired to device B's tag inputs and both loaded on the same edge, B emits 2*W bits per channel: B's word MSB first, then A's word MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sar_vld | input | NCH | Per-channel result-bit valid |
| sar_bit | input | NCH | Per-channel result bit, MSB first |
| convert | input | 1 | Copy input registers into holding latches |
| load | input | 1 | Transfer latches to output registers and start a frame |
| tag_in | input | NCH | Per-channel serial tag input, fed into the output register LSB |
| sdata | output | NCH | Per-channel serial data output |
| sync | output | 1 | Frame sync, high during the first bit of a frame |

## Verification
The assertions check three things on every cycle. The sync pulse must follow the load strobe exactly. The first bit shown after any load must equal the MSB of the latch that was held before that edge. The latch may change only on convert and must then take the input register. The bench scenarios are needed for the rest: the full MSB-first ordering over W shifts, the exact delay before tag bits reach the output, the 36-bit stream of two chained instances, the convert and load collision, and the dropping of bits offered without valid. These are swept over a range of computed word patterns and tag streams.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // default result width and channel count of the output stage
    localparam int unsigned SADC_WORD_W = 18;
    localparam int unsigned SADC_NCH    = 2;

    // operation applied to an output shift register at a bit-clock edge
    typedef enum logic {
        SH_SHIFT = 1'b0,
        SH_LOAD  = 1'b1
    } sh_op_e;

    // one result bit offered by the converter
    typedef struct packed {
        logic vld;
        logic val;
    } sar_beat_t;

    // a load strobe always wins over shifting
    function automatic sh_op_e pick_op(input logic ld);
        return ld ? SH_LOAD : SH_SHIFT;
    endfunction

endpackage

// File: rtl/sadc_capture.sv
module sadc_capture
    import sadc_pkg::*;
#(
    parameter int unsigned W = SADC_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sar_beat_t    beat,
    input  logic         convert,
    output logic [W-1:0] latch_q
);

    logic [W-1:0] in_q;

    // input shift register: collects result bits MSB first
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
        end else if (beat.vld) begin
            in_q <= {in_q[W-2:0], beat.val};
        end
    end

    // holding latch: taken only on a convert command
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (convert) begin
            latch_q <= in_q;
        end
    end

    // R3
    latch_take_chk: assert property (@(posedge clk) disable iff (rst)
        convert |=> latch_q == $past(in_q));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !convert |=> $stable(latch_q));

endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift
    import sadc_pkg::*;
#(
    parameter int unsigned W = SADC_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sh_op_e       op,
    input  logic [W-1:0] par_d,
    input  logic         tag,
    output logic         sdata
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            unique case (op)
                SH_LOAD:  sh_q <= par_d;
                default:  sh_q <= {sh_q[W-2:0], tag};
            endcase
        end
    end

    assign sdata = sh_q[W-1];

endmodule

// File: rtl/sadc_sync_gen.sv
module sadc_sync_gen (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic sync
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 1'b0;
        end else begin
            sync <= load;
        end
    end

endmodule

// File: rtl/sadc_serial_out.sv
module sadc_serial_out
    import sadc_pkg::*;
#(
    parameter int unsigned W   = SADC_WORD_W,
    parameter int unsigned NCH = SADC_NCH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] sar_vld,
    input  logic [NCH-1:0] sar_bit,
    input  logic           convert,
    input  logic           load,
    input  logic [NCH-1:0] tag_in,
    output logic [NCH-1:0] sdata,
    output logic           sync
);

    logic [NCH-1:0][W-1:0] latch_q;
    sh_op_e                op;

    assign op = pick_op(load);

    sadc_sync_gen u_sync (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .sync (sync)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sar_beat_t beat;
        assign beat.vld = sar_vld[c];
        assign beat.val = sar_bit[c];

        sadc_capture #(.W(W)) u_cap (
            .clk     (clk),
            .rst     (rst),
            .beat    (beat),
            .convert (convert),
            .latch_q (latch_q[c])
        );

        sadc_out_shift #(.W(W)) u_osr (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .par_d (latch_q[c]),
            .tag   (tag_in[c]),
            .sdata (sdata[c])
        );

        // R4, R8
        load_msb_chk: assert property (@(posedge clk) disable iff (rst)
            load |=> sdata[c] == $past(latch_q[c][W-1]));
    end

    // R5
    sync_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> sync);

    // R5
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> !sync);

endmodule

// File: tb/tb_sadc_serial_out.sv
module tb_sadc_serial_out;

    localparam int CLK_P = 10;
    localparam int W     = 18;
    localparam int NCH   = 2;
    localparam int NTAG  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] d_vld = '0, d_bit = '0, u_vld = '0, u_bit = '0;
    logic [NCH-1:0] u_tag = '0;
    logic conv = 1'b0, ld = 1'b0;
    logic [NCH-1:0] d_sdata, u_sdata;
    logic d_sync, u_sync;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    // upstream device of the chain
    sadc_serial_out #(.W(W), .NCH(NCH)) u_up (
        .clk (clk), .rst (rst), .sar_vld (u_vld), .sar_bit (u_bit),
        .convert (conv), .load (ld), .tag_in (u_tag),
        .sdata (u_sdata), .sync (u_sync)
    );

    // downstream device: its tags come from the upstream serial outputs
    sadc_serial_out #(.W(W), .NCH(NCH)) dut (
        .clk (clk), .rst (rst), .sar_vld (d_vld), .sar_bit (d_bit),
        .convert (conv), .load (ld), .tag_in (u_sdata),
        .sdata (d_sdata), .sync (d_sync)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] mkw(input int t, input int s);
        logic [31:0] v;
        if (t == 0) return {W{1'b1}} ^ {{(W-1){1'b0}}, s[0]};
        if (t == 1) return {W{1'b0}} | W'(s);
        if (t == 2) return {(W/2){2'b10}};
        if (t == 3) return {(W/2){2'b01}};
        v = 32'(t) * 32'd97531 + 32'(s) * 32'd12345 + 32'h2A5A5;
        v = v ^ (32'(t * t) * 32'd31) ^ (v >> 7);
        return v[W-1:0];
    endfunction

    function automatic logic tagf(input int n, input int c);
        return ((n * 3 + c * 5 + 1) % 7) < 3;
    endfunction

    // R2: supply one word per channel to both devices, optionally with dead cycles
    task automatic feed(input logic [NCH-1:0][W-1:0] dw, input logic [NCH-1:0][W-1:0] uw,
                        input bit gaps);
        for (int i = W - 1; i >= 0; i--) begin
            if (gaps && (i % 3 == 1)) begin
                d_vld = '0; u_vld = '0;
                d_bit = '1; u_bit = '1;
                @(negedge clk);
            end
            d_vld = '1; u_vld = '1;
            for (int c = 0; c < NCH; c++) begin
                d_bit[c] = dw[c][i];
                u_bit[c] = uw[c][i];
            end
            @(negedge clk);
        end
        d_vld = '0; u_vld = '0; d_bit = '0; u_bit = '0;
    endtask

    task automatic do_conv();
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
    endtask

    // load (optionally together with convert), then read the whole chained frame
    task automatic load_read(input logic [NCH-1:0][W-1:0] dw, input logic [NCH-1:0][W-1:0] uw,
                             input bit with_conv, input string tagname);
        ld = 1'b1;
        conv = with_conv;
        @(negedge clk);
        ld = 1'b0;
        conv = 1'b0;
        for (int n = 0; n < 2 * W + NTAG; n++) begin
            // R5: sync only in the first bit cycle
            chk("R5", d_sync, n == 0);
            chk("R5", u_sync, n == 0);
            for (int c = 0; c < NCH; c++) begin
                logic ue, de;
                ue = (n < W) ? uw[c][W-1-n] : tagf(n - W, c);
                if (n < W)          de = dw[c][W-1-n];
                else if (n < 2 * W) de = uw[c][2*W-1-n];
                else                de = tagf(n - 2 * W, c);
                // R4 R6 upstream word, R7 its tag tail
                chk((n < W) ? "R6" : "R7", u_sdata[c], ue);
                // R10 chained frame, R9 per channel
                chk((n < W) ? tagname : "R10", d_sdata[c], de);
                u_tag[c] = tagf(n, c);
            end
            @(negedge clk);
        end
        u_tag = '0;
    endtask

    initial begin
        logic [NCH-1:0][W-1:0] dw, uw, dx, ux;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared outputs
        chk("R1", d_sync, 1'b0);
        chk("R1", u_sync, 1'b0);
        for (int c = 0; c < NCH; c++) begin
            chk("R1", d_sdata[c], 1'b0);
            chk("R1", u_sdata[c], 1'b0);
        end
        // R1: load without convert sends zero words
        load_read('0, '0, 1'b0, "R1");

        // R2 R3 R4 R6 R7 R9 R10: sweep of word patterns
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < NCH; c++) begin
                dw[c] = mkw(t, 2 * c);
                uw[c] = mkw(t + 40, 2 * c + 1);
            end
            feed(dw, uw, t[0]);
            do_conv();
            load_read(dw, uw, 1'b0, "R4");
        end

        // R3: new bits without convert do not reach the output
        for (int c = 0; c < NCH; c++) begin
            dx[c] = ~dw[c];
            ux[c] = ~uw[c] ^ W'(c + 5);
        end
        feed(dx, ux, 1'b0);
        load_read(dw, uw, 1'b0, "R3");

        // R8: convert and load on the same edge
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c < NCH; c++) begin
                dw[c] = mkw(t + 70, c);
                uw[c] = mkw(t + 90, c + 3);
                dx[c] = mkw(t + 110, c + 1);
                ux[c] = mkw(t + 130, c + 2);
            end
            feed(dw, uw, 1'b0);
            do_conv();
            feed(dx, ux, 1'b1);
            load_read(dw, uw, 1'b1, "R8");
            load_read(dx, ux, 1'b0, "R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule